// File: doc/BRIEF.md
# Flash Write Cycle Qualifier

This block sits between the asynchronous control pins of a flash memory and its command state machine. It watches chip enable, write enable and output enable, all active low, and decides whether each bus cycle is a real write to the command register. A write cycle ends on the rising edge of write enable. The block emits a one-clock `wr_strobe` for that cycle only if every check below passes:

- each pin has been cleaned of short glitches;
- chip enable stayed low and output enable stayed high for the whole low phase of write enable;
- the cycle is not the first write-enable rise after a power-up that began in the write state;
- the supply-lockout input was not asserted.

It also drives `force_read`, which tells the state machine to go back to read mode. This happens at power-up and each time the supply lockout is raised. The block only qualifies cycles: it carries no data. Voltage sensing happens elsewhere, and the lockout arrives here as a digital level.

Each pin goes through a two-flop synchronizer and then a run-length filter. The filtered level changes only after the synchronized pin has held a new value for `FILT_CYCLES` consecutive clocks. `FILT_CYCLES` must be at least 3. Choose it so that `FILT_CYCLES` clock periods cover the longest glitch the board may produce.

Top module: `flash_write_qualifier`

## Requirements
- R1: `wr_strobe` is low in reset. It is high for exactly one clock for each accepted write, and only after the filtered write enable rises.
- R2: If output enable is low, and held long enough to pass the filter, at any point in the write-enable low phase, no strobe is produced for that cycle.
- R3: If chip enable is high, and held long enough to pass the filter, at any point in the write-enable low phase, no strobe is produced for that cycle.
- R4: A level change on any pin that lasts fewer than `FILT_CYCLES` clocks is ignored. A write-enable low pulse of `FILT_CYCLES` clocks or more, with the other pins qualifying, is accepted.
- R5: Suppose the block leaves reset with chip enable and write enable low and output enable high. The first rise of write enable then produces no strobe, and later writes are accepted.
- R6: If the block leaves reset with the pins idle (all high), the first well-formed write is accepted.
- R7: No strobe is produced for a write whose low phase overlaps the synchronized lockout level, even in part, or for a write made while lockout is held.
- R8: `force_read` is high during reset and low after the first clock edge following reset release, provided lockout is low.
- R9: `force_read` pulses for exactly one clock when the lockout input rises. It stays low while lockout is held and when lockout falls.
- R10: Write enable rises at the pin just before clock edge E0. `wr_strobe` is then high during the cycle after edge E(`FILT_CYCLES`+3), and low in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip-enable pin, active low, asynchronous |
| we_n | input | 1 | Write-enable pin, active low, asynchronous |
| oe_n | input | 1 | Output-enable pin, active low, asynchronous |
| lockout | input | 1 | High while supply is below the write-lockout threshold |
| wr_strobe | output | 1 | One-clock pulse per accepted command write |
| force_read | output | 1 | Request to put the command state machine in read mode |

## Verification
The checker tests several properties on every clock:

- each strobe is followed by a low cycle;
- a strobe always comes after a filtered write-enable low phase, with chip enable low and output enable high, ending in a rise;
- no strobe appears while the power-up guard is armed or the synchronized lockout is high;
- `force_read` never stays high for two cycles after reset.

Some behaviour can only be shown by the bench's directed scenarios:

- that a glitch shorter than the filter window leaves the outcome unchanged;
- that a power-up in the write state blocks one edge and only one;
- that a lockout overlapping part of a low phase cancels that write;
- the exact strobe latency.

// File: rtl/flash_wq_pkg.sv
package flash_wq_pkg;
  localparam int NUM_PINS = 3;
  localparam int PIN_CE   = 0;
  localparam int PIN_WE   = 1;
  localparam int PIN_OE   = 2;

  typedef struct packed {
    logic oe_n;
    logic we_n;
    logic ce_n;
  } ctrl_pins_t;
endpackage

// File: rtl/wq_pin_filter.sv
module wq_pin_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic filt_n,
  output logic settled
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(FILT_CYCLES);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          sync1_q, sync2_q, cand_q;
  logic [CW-1:0] run_q;

  // Two-flop synchronizer, then a run-length count of identical samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      cand_q  <= 1'b1;
      run_q   <= '0;
      filt_n  <= 1'b1;
      settled <= 1'b0;
    end else begin
      sync1_q <= pin_n;
      sync2_q <= sync1_q;
      if (sync2_q != cand_q) begin
        cand_q <= sync2_q;
        run_q  <= CNT_ONE;
      end else if (run_q != CNT_TOP) begin
        run_q <= run_q + 1'b1;
      end
      if (run_q == CNT_TOP) begin
        filt_n  <= cand_q;
        settled <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wq_supply_lock.sv
module wq_supply_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lockout,
  output logic lock_s,
  output logic force_read
);
  logic lk1_q, lk2_q, lkd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk1_q      <= 1'b0;
      lk2_q      <= 1'b0;
      lkd_q      <= 1'b0;
      force_read <= 1'b1;
    end else begin
      lk1_q      <= lockout;
      lk2_q      <= lk1_q;
      lkd_q      <= lk2_q;
      force_read <= lk2_q & ~lkd_q;
    end
  end

  assign lock_s = lk2_q;
endmodule

// File: rtl/wq_cycle_track.sv
module wq_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic all_set,
  input  logic ce_f,
  input  logic we_f,
  input  logic oe_f,
  input  logic lock_s,
  output logic wr_strobe,
  output logic guard_armed
);
  logic we_prev_q, ok_q;
  logic pins_good, we_fall, we_rise;

  assign pins_good = !ce_f && oe_f && !lock_s;
  assign we_fall   = we_prev_q && !we_f;
  assign we_rise   = !we_prev_q && we_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q   <= 1'b1;
      ok_q        <= 1'b0;
      wr_strobe   <= 1'b0;
      guard_armed <= 1'b1;
    end else begin
      we_prev_q <= we_f;
      // Low-phase qualification: set on entry, cleared by any bad sample.
      if (!all_set)     ok_q <= 1'b0;
      else if (we_fall) ok_q <= pins_good;
      else if (!we_f)   ok_q <= ok_q && pins_good;
      // Strobe on the filtered rise of write enable.
      wr_strobe <= all_set && we_rise && ok_q && !guard_armed && !lock_s;
      // Power-up guard drops once write or chip enable is seen high.
      if (all_set && (we_f || ce_f)) guard_armed <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_write_qualifier.sv
module flash_write_qualifier
  import flash_wq_pkg::*;
#(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic lockout,
  output logic wr_strobe,
  output logic force_read
);
  ctrl_pins_t          raw_pins;
  logic [NUM_PINS-1:0] raw_vec, filt_vec, set_vec;
  logic                ce_filt, we_filt, oe_filt, all_set;
  logic                lock_sync, guard_armed;

  assign raw_pins = '{oe_n: oe_n, we_n: we_n, ce_n: ce_n};
  assign raw_vec  = raw_pins;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_filt
    wq_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (raw_vec[gi]),
      .filt_n (filt_vec[gi]),
      .settled(set_vec[gi])
    );
  end

  assign ce_filt = filt_vec[PIN_CE];
  assign we_filt = filt_vec[PIN_WE];
  assign oe_filt = filt_vec[PIN_OE];
  assign all_set = &set_vec;

  wq_supply_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .lockout   (lockout),
    .lock_s    (lock_sync),
    .force_read(force_read)
  );

  wq_cycle_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .all_set    (all_set),
    .ce_f       (ce_filt),
    .we_f       (we_filt),
    .oe_f       (oe_filt),
    .lock_s     (lock_sync),
    .wr_strobe  (wr_strobe),
    .guard_armed(guard_armed)
  );
endmodule

// File: rtl/wq_checker.sv
module wq_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_strobe,
  input logic force_read,
  input logic we_f,
  input logic ce_f,
  input logic oe_f,
  input logic lock_s,
  input logic guard
);
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R2, R3: strobe only after a qualified low phase that then rose
  a_r2_r3_qualified_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($past(we_f, 2) == 1'b0 && $past(ce_f, 2) == 1'b0 &&
                   $past(oe_f, 2) == 1'b1 && $past(we_f) == 1'b1));

  a_r5_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(guard) |-> !wr_strobe);

  a_r7_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_s) |-> !wr_strobe);

  a_r9_force_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    force_read |=> !force_read);
endmodule

bind flash_write_qualifier wq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_strobe (wr_strobe),
  .force_read(force_read),
  .we_f      (we_filt),
  .ce_f      (ce_filt),
  .oe_f      (oe_filt),
  .lock_s    (lock_sync),
  .guard     (guard_armed)
);

// File: tb/flash_write_qualifier_bench.sv
`timescale 1ns/1ps
module flash_write_qualifier_bench;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lockout = 1'b0;
  logic wr_strobe, force_read;

  int checks = 0;
  int fails  = 0;
  int strobe_cnt = 0;
  int fr_cnt = 0;

  always #5 clk = ~clk;

  flash_write_qualifier #(.FILT_CYCLES(FILT)) u_flash_write_qualifier (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lockout(lockout), .wr_strobe(wr_strobe), .force_read(force_read)
  );

  always @(negedge clk) begin
    if (rst_n && wr_strobe)  strobe_cnt++;
    if (rst_n && force_read) fr_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic c, input logic w, input logic o);
    @(negedge clk);
    rst_n = 1'b0; ce_n = c; we_n = w; oe_n = o; lockout = 1'b0;
    cyc(3);
    check("R8 force_read in reset", force_read, 1);
    check("R1 strobe in reset", wr_strobe, 0);
    rst_n = 1'b1;
    cyc(1);
    check("R8 force_read after release", force_read, 0);
    cyc(20);
  endtask

  task automatic do_write(input int low_cycles);
    ce_n = 1'b0; cyc(10);
    we_n = 1'b0; cyc(low_cycles);
    we_n = 1'b1; cyc(20);
    ce_n = 1'b1; cyc(10);
  endtask

  task automatic t_idle_powerup;
    int s0;
    do_reset(1'b1, 1'b1, 1'b1);
    s0 = strobe_cnt;
    do_write(8);
    check("R6 first write after idle power-up", strobe_cnt - s0, 1);
  endtask

  task automatic t_latency;
    int s0;
    s0 = strobe_cnt;
    ce_n = 1'b0; cyc(10);
    we_n = 1'b0; cyc(10);
    we_n = 1'b1;
    cyc(FILT + 3);
    check("R10 strobe not yet", wr_strobe, 0);
    cyc(1);
    check("R10 strobe at latency", wr_strobe, 1);
    cyc(1);
    check("R1 strobe one cycle", wr_strobe, 0);
    cyc(10); ce_n = 1'b1; cyc(10);
    check("R1 one strobe per write", strobe_cnt - s0, 1);
  endtask

  task automatic t_oe_block;
    int s0;
    s0 = strobe_cnt;
    ce_n = 1'b0; cyc(10);
    we_n = 1'b0; cyc(6);
    oe_n = 1'b0; cyc(8);
    oe_n = 1'b1; cyc(8);
    we_n = 1'b1; cyc(20);
    ce_n = 1'b1; cyc(10);
    check("R2 oe low in phase blocks", strobe_cnt - s0, 0);
  endtask

  task automatic t_ce_block;
    int s0;
    s0 = strobe_cnt;
    ce_n = 1'b0; cyc(10);
    we_n = 1'b0; cyc(6);
    ce_n = 1'b1; cyc(8);
    ce_n = 1'b0; cyc(8);
    we_n = 1'b1; cyc(20);
    ce_n = 1'b1; cyc(10);
    check("R3 ce high in phase blocks", strobe_cnt - s0, 0);
  endtask

  task automatic t_glitch;
    int s0;
    s0 = strobe_cnt;
    do_write(FILT - 1);
    check("R4 short we pulse ignored", strobe_cnt - s0, 0);
    s0 = strobe_cnt;
    do_write(FILT);
    check("R4 we pulse of window accepted", strobe_cnt - s0, 1);
    s0 = strobe_cnt;
    ce_n = 1'b0; cyc(10);
    we_n = 1'b0; cyc(6);
    ce_n = 1'b1; cyc(FILT - 1);
    ce_n = 1'b0; cyc(4);
    oe_n = 1'b0; cyc(FILT - 1);
    oe_n = 1'b1; cyc(8);
    we_n = 1'b1; cyc(20);
    ce_n = 1'b1; cyc(10);
    check("R4 ce/oe glitches ignored", strobe_cnt - s0, 1);
  endtask

  task automatic t_write_state_powerup;
    int s0;
    do_reset(1'b0, 1'b0, 1'b1);
    s0 = strobe_cnt;
    we_n = 1'b1; cyc(20);
    ce_n = 1'b1; cyc(10);
    check("R5 first edge after write-state power-up blocked", strobe_cnt - s0, 0);
    s0 = strobe_cnt;
    do_write(8);
    check("R5 later write accepted", strobe_cnt - s0, 1);
  endtask

  task automatic t_lockout;
    int s0, f0;
    f0 = fr_cnt;
    lockout = 1'b1; cyc(10);
    check("R9 one force_read pulse on lockout rise", fr_cnt - f0, 1);
    s0 = strobe_cnt;
    do_write(8);
    check("R7 write during lockout ignored", strobe_cnt - s0, 0);
    check("R9 no pulse while held", fr_cnt - f0, 1);
    lockout = 1'b0; cyc(10);
    check("R9 no pulse on lockout fall", fr_cnt - f0, 1);
    s0 = strobe_cnt;
    ce_n = 1'b0; cyc(10);
    we_n = 1'b0; cyc(5);
    lockout = 1'b1; cyc(6);
    lockout = 1'b0; cyc(10);
    we_n = 1'b1; cyc(20);
    ce_n = 1'b1; cyc(10);
    check("R7 lockout overlapping phase blocks", strobe_cnt - s0, 0);
    s0 = strobe_cnt;
    do_write(8);
    check("R7 write accepted after lockout", strobe_cnt - s0, 1);
  endtask

  initial begin
    t_idle_powerup();
    t_latency();
    t_oe_block();
    t_ce_block();
    t_glitch();
    t_write_state_powerup();
    t_lockout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule